// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses which oscillator drives the system clock and sequences the handover whenever software writes a new source selection. Software writes a 2-bit source code together with a 3-bit internal-RC frequency code; the block waits for the chosen oscillator to report ready. If the target is the primary oscillator running in a crystal mode, it then counts a fixed number of that oscillator's cycles as a start-up delay before the new source takes over.

One ripple counter serves two purposes. In normal running it is the watchdog counter. During a handover it is borrowed as the start-up timer, so the watchdog is suspended. When the handover ends, the counter is cleared and watchdog counting resumes from zero on the new clock. Read-only status tells software whether the primary clock is in use and whether the internal oscillator has settled. The clock multiplexer itself, the oscillators and the watchdog reset logic are outside this block.

Top module: `clksw_ctrl`

## Requirements
- R1: The source code maps 00 to the primary oscillator, 01 to the low-power timer oscillator and 10 to the internal RC oscillator. `src_o` reports the running source with the same encoding.
- R2: While a handover is in progress, `wdt_run_o` is 0 and watchdog ticks do not advance `rip_cnt_o`.
- R3: A handover to the primary oscillator in a crystal mode (`prim_mode_i` 000, 001 or 010) completes only after OST_CYCLES primary ticks, 1026 edges after the write at default settings with ticks every cycle. A handover to any other source, or to a primary mode from 011 upward, completes on the second edge after the write when the target is ready.
- R4: The edge that completes a handover clears `rip_cnt_o`. Watchdog counting then resumes from zero.
- R5: `startup_ok_o` is 1 exactly when the primary oscillator is the running source, from the first edge after reset onward.
- R6: `intrc_stable_o` follows `intrc_rdy_i` one edge late. It is forced to 0 for the edge after a write that changes the frequency code.
- R7: Every write loads `ctl_freq_i` into `intrc_freq_o`, codes 000 to 111 standing for 31.25 kHz up to 8 MHz, visible after the write's edge.
- R8: A write of source code 11 leaves the source, the handover state and the counter untouched.
- R9: A write made during a handover restarts the sequence toward the newest source.
- R10: A handover waits, with the counter held at 0, for as long as the target's ready input is low.
- R11: With `two_speed_i` high and a crystal primary mode, the block leaves reset running from the internal RC oscillator with `startup_ok_o` at 0. It then hands over to the primary oscillator by itself.
- R12: A write that selects the running source while idle starts no handover and does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_sel_i | input | 2 | Requested source code |
| ctl_freq_i | input | 3 | Internal RC frequency code |
| prim_mode_i | input | 3 | Configured primary oscillator mode (000..010 crystal) |
| two_speed_i | input | 1 | Two-speed start-up enabled |
| prim_rdy_i | input | 1 | Primary oscillator ready |
| lpt_rdy_i | input | 1 | Low-power timer oscillator ready |
| intrc_rdy_i | input | 1 | Internal RC oscillator ready/stable |
| prim_tick_i | input | 1 | One pulse per primary oscillator cycle |
| wdt_tick_i | input | 1 | Watchdog count enable pulse |
| wdt_en_i | input | 1 | Watchdog enabled by configuration |
| src_o | output | 2 | Running clock source |
| switching_o | output | 1 | Handover in progress |
| wdt_run_o | output | 1 | Watchdog counting active |
| startup_ok_o | output | 1 | Running from primary clock |
| intrc_stable_o | output | 1 | Internal oscillator frequency stable |
| intrc_freq_o | output | 3 | Held frequency code |
| rip_cnt_o | output | CNT_W | Shared ripple counter value |

## Verification
Every cycle, the embedded properties check the following: the counter clears on completion, the start-up phase is entered only toward a crystal primary, the source changes only at a completion, the status bit agrees with the running source, and reserved writes start nothing. Handover latencies, the restart toward a newer selection, waiting on a late ready, the suspended watchdog count and the two-speed boot sequence need multi-step scenarios. Only the bench's table walk and directed tests show those.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [1:0] {
        SRC_PRIM = 2'd0,
        SRC_LPT  = 2'd1,
        SRC_INT  = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        PH_BOOT = 2'd0,
        PH_IDLE = 2'd1,
        PH_WAIT = 2'd2,
        PH_OST  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        src_e   act;
        src_e   tgt;
    } seq_st_t;

    typedef struct packed {
        logic       startup;
        logic       stable;
        logic [2:0] freq;
    } stat_st_t;

    // primary modes 000..010 need a crystal start-up delay
    function automatic logic is_xtal(logic [2:0] mode);
        return mode <= 3'd2;
    endfunction

    function automatic src_e dec_sel(logic [1:0] code);
        src_e r;
        unique case (code)
            2'b00:   r = SRC_PRIM;
            2'b01:   r = SRC_LPT;
            default: r = SRC_INT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clksw_ripple_cnt.sv
module clksw_ripple_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !inc_i) |=> $stable(cnt_o));

    // R4
    cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int OST_CYCLES = 1024
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [1:0]       sel_i,
    input  logic [2:0]       prim_mode_i,
    input  logic             two_speed_i,
    input  logic             prim_rdy_i,
    input  logic             lpt_rdy_i,
    input  logic             intrc_rdy_i,
    input  logic             prim_tick_i,
    input  logic             wdt_tick_i,
    input  logic             wdt_en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output src_e             act_o,
    output logic             switching_o,
    output logic             wdt_run_o,
    output logic             done_o,
    output src_e             done_src_o,
    output logic             boot_o
);

    localparam logic [CNT_W-1:0] OST_LAST = CNT_W'(OST_CYCLES - 1);

    seq_st_t s_d, s_q;
    logic    tgt_rdy;
    logic    ost_last;
    src_e    req;

    always_comb begin
        s_d       = s_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        done_o    = 1'b0;
        req       = dec_sel(sel_i);

        unique case (s_q.tgt)
            SRC_PRIM: tgt_rdy = prim_rdy_i;
            SRC_LPT:  tgt_rdy = lpt_rdy_i;
            default:  tgt_rdy = intrc_rdy_i;
        endcase
        ost_last = prim_tick_i && (cnt_i == OST_LAST);

        unique case (s_q.phase)
            PH_BOOT: begin
                cnt_clr_o = 1'b1;
                if (two_speed_i && is_xtal(prim_mode_i)) begin
                    s_d.act   = SRC_INT;
                    s_d.tgt   = SRC_PRIM;
                    s_d.phase = PH_WAIT;
                end else begin
                    s_d.act   = SRC_PRIM;
                    s_d.tgt   = SRC_PRIM;
                    s_d.phase = PH_IDLE;
                end
            end
            PH_IDLE: begin
                cnt_inc_o = wdt_en_i && wdt_tick_i;
            end
            PH_WAIT: begin
                if (tgt_rdy) begin
                    cnt_clr_o = 1'b1;
                    if (s_q.tgt == SRC_PRIM && is_xtal(prim_mode_i)) begin
                        s_d.phase = PH_OST;
                    end else begin
                        done_o    = 1'b1;
                        s_d.act   = s_q.tgt;
                        s_d.phase = PH_IDLE;
                    end
                end
            end
            PH_OST: begin
                cnt_inc_o = prim_tick_i;
                if (ost_last) begin
                    cnt_clr_o = 1'b1;
                    done_o    = 1'b1;
                    s_d.act   = s_q.tgt;
                    s_d.phase = PH_IDLE;
                end
            end
            default: s_d.phase = PH_BOOT;
        endcase

        // newest valid request wins; reserved code is ignored
        if (s_q.phase != PH_BOOT && wr_i && sel_i != 2'b11) begin
            if (!(s_q.phase == PH_IDLE && req == s_q.act)) begin
                s_d.tgt   = req;
                s_d.phase = PH_WAIT;
                cnt_clr_o = 1'b1;
                cnt_inc_o = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_BOOT, act: SRC_PRIM, tgt: SRC_PRIM};
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o       = s_q.act;
    assign done_src_o  = s_q.tgt;
    assign boot_o      = (s_q.phase == PH_BOOT);
    assign switching_o = (s_q.phase == PH_WAIT) || (s_q.phase == PH_OST);
    assign wdt_run_o   = (s_q.phase == PH_IDLE) && wdt_en_i;

    // R3
    ost_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_OST) |-> (s_q.tgt == SRC_PRIM && is_xtal(prim_mode_i)));

    // R1
    act_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase != PH_BOOT && !done_o) |=> $stable(act_o));

endmodule

// File: rtl/clksw_status.sv
module clksw_status
    import clksw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [2:0] freq_i,
    input  logic       intrc_rdy_i,
    input  logic       boot_i,
    input  logic       two_speed_i,
    input  logic [2:0] prim_mode_i,
    input  logic       done_i,
    input  src_e       done_src_i,
    output logic       startup_o,
    output logic       stable_o,
    output logic [2:0] freq_o
);

    stat_st_t t_d, t_q;
    logic     fchg;

    always_comb begin
        t_d  = t_q;
        fchg = wr_i && (freq_i != t_q.freq);
        if (wr_i) begin
            t_d.freq = freq_i;
        end
        t_d.stable = intrc_rdy_i && !fchg;
        if (boot_i) begin
            t_d.startup = !(two_speed_i && is_xtal(prim_mode_i));
        end else if (done_i) begin
            t_d.startup = (done_src_i == SRC_PRIM);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q <= '{startup: 1'b0, stable: 1'b0, freq: 3'b000};
        end else begin
            t_q <= t_d;
        end
    end

    assign startup_o = t_q.startup;
    assign stable_o  = t_q.stable;
    assign freq_o    = t_q.freq;

    // R6
    unstable_after_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && freq_i != freq_o) |=> !stable_o);

    // R7
    freq_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (freq_o == $past(freq_i)));

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int OST_CYCLES = 1024
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_wr_i,
    input  logic [1:0]       ctl_sel_i,
    input  logic [2:0]       ctl_freq_i,
    input  logic [2:0]       prim_mode_i,
    input  logic             two_speed_i,
    input  logic             prim_rdy_i,
    input  logic             lpt_rdy_i,
    input  logic             intrc_rdy_i,
    input  logic             prim_tick_i,
    input  logic             wdt_tick_i,
    input  logic             wdt_en_i,
    output logic [1:0]       src_o,
    output logic             switching_o,
    output logic             wdt_run_o,
    output logic             startup_ok_o,
    output logic             intrc_stable_o,
    output logic [2:0]       intrc_freq_o,
    output logic [CNT_W-1:0] rip_cnt_o
);

    logic cnt_clr, cnt_inc, done, boot;
    src_e act, done_src;

    clksw_seq #(
        .CNT_W      (CNT_W),
        .OST_CYCLES (OST_CYCLES)
    ) seq_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (ctl_wr_i),
        .sel_i       (ctl_sel_i),
        .prim_mode_i (prim_mode_i),
        .two_speed_i (two_speed_i),
        .prim_rdy_i  (prim_rdy_i),
        .lpt_rdy_i   (lpt_rdy_i),
        .intrc_rdy_i (intrc_rdy_i),
        .prim_tick_i (prim_tick_i),
        .wdt_tick_i  (wdt_tick_i),
        .wdt_en_i    (wdt_en_i),
        .cnt_i       (rip_cnt_o),
        .cnt_clr_o   (cnt_clr),
        .cnt_inc_o   (cnt_inc),
        .act_o       (act),
        .switching_o (switching_o),
        .wdt_run_o   (wdt_run_o),
        .done_o      (done),
        .done_src_o  (done_src),
        .boot_o      (boot)
    );

    clksw_ripple_cnt #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (rip_cnt_o)
    );

    clksw_status stat_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (ctl_wr_i),
        .freq_i      (ctl_freq_i),
        .intrc_rdy_i (intrc_rdy_i),
        .boot_i      (boot),
        .two_speed_i (two_speed_i),
        .prim_mode_i (prim_mode_i),
        .done_i      (done),
        .done_src_i  (done_src),
        .startup_o   (startup_ok_o),
        .stable_o    (intrc_stable_o),
        .freq_o      (intrc_freq_o)
    );

    assign src_o = act;

    // R4
    wdt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |=> (rip_cnt_o == '0));

    // R5
    startup_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !boot |-> (startup_ok_o == (src_o == SRC_PRIM)));

    // R8
    reserved_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!boot && !switching_o && ctl_wr_i && ctl_sel_i == 2'b11) |=> !switching_o);

endmodule

// File: tb/clksw_ctrl_tb_top.sv
module clksw_ctrl_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_ni;
    logic             ctl_wr_i;
    logic [1:0]       ctl_sel_i;
    logic [2:0]       ctl_freq_i;
    logic [2:0]       prim_mode_i;
    logic             two_speed_i;
    logic             prim_rdy_i, lpt_rdy_i, intrc_rdy_i;
    logic             prim_tick_i, wdt_tick_i, wdt_en_i;
    logic [1:0]       src_o;
    logic             switching_o, wdt_run_o, startup_ok_o, intrc_stable_o;
    logic [2:0]       intrc_freq_o;
    logic [CNT_W-1:0] rip_cnt_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    clksw_ctrl #(.CNT_W(CNT_W), .OST_CYCLES(1024)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr_i), .ctl_sel_i(ctl_sel_i),
        .ctl_freq_i(ctl_freq_i), .prim_mode_i(prim_mode_i), .two_speed_i(two_speed_i),
        .prim_rdy_i(prim_rdy_i), .lpt_rdy_i(lpt_rdy_i), .intrc_rdy_i(intrc_rdy_i),
        .prim_tick_i(prim_tick_i), .wdt_tick_i(wdt_tick_i), .wdt_en_i(wdt_en_i),
        .src_o(src_o), .switching_o(switching_o), .wdt_run_o(wdt_run_o),
        .startup_ok_o(startup_ok_o), .intrc_stable_o(intrc_stable_o),
        .intrc_freq_o(intrc_freq_o), .rip_cnt_o(rip_cnt_o)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [2:0]  pm;
        logic [2:0]  fq;
        logic [1:0]  src;
        logic        st;
        logic [10:0] lat;
    } vec_t;

    // sel, primary mode, freq code, expected source, startup bit, edges to finish
    localparam vec_t VECS [7] = '{
        '{2'b10, 3'd3, 3'd1, 2'd2, 1'b0, 11'd2},
        '{2'b01, 3'd3, 3'd2, 2'd1, 1'b0, 11'd2},
        '{2'b00, 3'd2, 3'd3, 2'd0, 1'b1, 11'd1026},
        '{2'b10, 3'd2, 3'd4, 2'd2, 1'b0, 11'd2},
        '{2'b00, 3'd3, 3'd5, 2'd0, 1'b1, 11'd2},
        '{2'b01, 3'd4, 3'd6, 2'd1, 1'b0, 11'd2},
        '{2'b00, 3'd0, 3'd7, 2'd0, 1'b1, 11'd1026}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drives one write and returns after its edge
    task automatic wr(input logic [1:0] sel, input logic [2:0] fq);
        ctl_wr_i   = 1'b1;
        ctl_sel_i  = sel;
        ctl_freq_i = fq;
        step(1);
        ctl_wr_i   = 1'b0;
    endtask

    task automatic wait_idle(output int k);
        k = 0;
        while (switching_o && k < 3000) begin
            step(1);
            k++;
        end
    endtask

    task automatic do_reset(input logic ts, input logic [2:0] pm);
        rst_ni = 1'b0;
        two_speed_i = ts;
        prim_mode_i = pm;
        step(3);
        chk("R5 reset startup", int'(startup_ok_o), 0);
        chk("R2 reset count", int'(rip_cnt_o), 0);
        rst_ni = 1'b1;
        step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        int c0;
        ctl_wr_i = 0; ctl_sel_i = 0; ctl_freq_i = 0;
        prim_rdy_i = 1; lpt_rdy_i = 1; intrc_rdy_i = 1;
        prim_tick_i = 1; wdt_tick_i = 1; wdt_en_i = 1;
        rst_ni = 0;
        @(negedge clk);

        do_reset(1'b0, 3'd3);
        chk("R1 boot src", int'(src_o), 0);
        chk("R5 boot startup", int'(startup_ok_o), 1);
        chk("R3 boot not switching", int'(switching_o), 0);
        chk("R7 reset freq", int'(intrc_freq_o), 0);

        for (int v = 0; v < 7; v++) begin
            prim_mode_i = VECS[v].pm;
            wr(VECS[v].sel, VECS[v].fq);
            chk("R2 wdt suspended", int'(wdt_run_o), 0);
            wait_idle(k);
            chk("R3 latency", k + 1, int'(VECS[v].lat));
            chk("R1 source", int'(src_o), int'(VECS[v].src));
            chk("R5 startup", int'(startup_ok_o), int'(VECS[v].st));
            chk("R7 freq", int'(intrc_freq_o), int'(VECS[v].fq));
            chk("R4 count cleared", int'(rip_cnt_o), 0);
            step(1);
            chk("R4 count resumes", int'(rip_cnt_o), 1);
        end

        // R10 / R2: target not ready, watchdog ticks keep arriving
        prim_mode_i = 3'd3;
        lpt_rdy_i = 1'b0;
        wr(2'b01, 3'd7);
        step(5);
        chk("R10 still switching", int'(switching_o), 1);
        chk("R2 count held", int'(rip_cnt_o), 0);
        chk("R2 wdt off", int'(wdt_run_o), 0);
        chk("R10 old src kept", int'(src_o), 0);
        lpt_rdy_i = 1'b1;
        step(1);
        chk("R10 done on ready", int'(switching_o), 0);
        chk("R10 src", int'(src_o), 1);
        step(4);

        // R8 reserved code, also changes frequency code (R6, R7)
        c0 = int'(rip_cnt_o);
        wr(2'b11, 3'd5);
        chk("R8 no switch", int'(switching_o), 0);
        chk("R8 src kept", int'(src_o), 1);
        chk("R8 count kept", int'(rip_cnt_o), c0 + 1);
        chk("R7 freq on reserved", int'(intrc_freq_o), 5);
        chk("R6 unstable after change", int'(intrc_stable_o), 0);
        step(1);
        chk("R6 stable again", int'(intrc_stable_o), 1);

        // R12 same source while idle
        c0 = int'(rip_cnt_o);
        wr(2'b01, 3'd5);
        chk("R12 no switch", int'(switching_o), 0);
        chk("R12 count kept", int'(rip_cnt_o), c0 + 1);
        chk("R6 same code stays stable", int'(intrc_stable_o), 1);

        intrc_rdy_i = 1'b0;
        step(1);
        chk("R6 follows ready", int'(intrc_stable_o), 0);
        intrc_rdy_i = 1'b1;
        step(1);

        // R9 restart during start-up count
        prim_mode_i = 3'd2;
        wr(2'b00, 3'd5);
        step(10);
        chk("R9 counting", int'(rip_cnt_o) > 0 ? 1 : 0, 1);
        wr(2'b10, 3'd5);
        chk("R9 restarted", int'(switching_o), 1);
        chk("R9 count cleared", int'(rip_cnt_o), 0);
        wait_idle(k);
        chk("R9 latency", k + 1, 2);
        chk("R9 newest src", int'(src_o), 2);
        chk("R5 not primary", int'(startup_ok_o), 0);

        // R11 two-speed boot with crystal mode
        do_reset(1'b1, 3'd1);
        chk("R11 boot on internal", int'(src_o), 2);
        chk("R11 startup low", int'(startup_ok_o), 0);
        chk("R11 switching", int'(switching_o), 1);
        wait_idle(k);
        chk("R11 handover length", k, 1025);
        chk("R11 primary", int'(src_o), 0);
        chk("R11 startup high", int'(startup_ok_o), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule